// File: doc/BRIEF.md
# Flash Security Unlock Controller

This block keeps the secure/unsecured status of an on-chip nonvolatile memory. While the synchronous reset is held, it takes a configuration byte from nonvolatile storage. The two low bits of that byte set whether the memory starts out secured. The top bit allows or forbids unlocking by key. Bit 6 is a redirect-disable flag that the block stores and drives out unchanged.

Once reset is released, there are two ways to lift security. Neither lasts past the next reset. The first is an eight-byte key that code running from secure memory writes in order, byte slot 0 first. The block compares each byte with the stored key. When the eighth byte is written and every byte has matched, it releases security. A key write that comes from the debug port is dropped. The second way is a completed mass erase followed by a passing blank check. This path works whether or not key unlocking is allowed.

Top module: `flash_sec_ctrl`

## Requirements
- R1: While `rst_n` is low, each clock edge loads the secure flag from `opt_byte[1:0]`. The value 2'b10 gives `secure_o`=0 (unsecured). Every other value gives `secure_o`=1.
- R2: `no_redir_o` equals `opt_byte[6]` as it was captured during reset, and it holds that value until the next reset. The key-enable bit is `opt_byte[7]` (1 = allowed), captured at the same time.
- R3: Suppose key-enable is 1 and the block is secured. Eight key writes from secure code, to `kw_idx` 0,1,...,7 in that order, each with `kw_data` equal to byte `key_ref[8*i+7:8*i]`, clear `secure_o` on the clock edge that captures the eighth write. After seven writes `secure_o` is still 1.
- R4: When key-enable is 0, no key sequence changes `secure_o`.
- R5: A key write with `kw_from_dbg`=1 is ignored. It does not advance the sequence, it does not count as a failure, and it never unlocks.
- R6: If the eighth byte completes a sequence in which any byte was wrong, the block stays secured. A write to a slot other than the next expected one is a failure straight away. After a failure, every later key sequence is rejected until reset.
- R7: An `erase_done` pulse followed, on a later cycle, by a `blank_pass` pulse clears `secure_o` on the edge that captures `blank_pass`. This holds whatever the key-enable or failure state. A `blank_pass` with no earlier `erase_done` since reset is ignored.
- R8: Unlocking lasts only until reset. The next reset reloads `secure_o` from `opt_byte[1:0]`.
- R9: Once `secure_o` is 0, nothing sets it back to 1 except reset. Key writes of any value leave it at 0.
- R10: The eighth byte of a failing key sequence and a valid `blank_pass` can arrive in the same cycle. In that case the blank-check unlock takes effect and `secure_o` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the option byte is loaded while it is low |
| opt_byte | input | 8 | Nonvolatile option byte: [7] key enable, [6] redirect disable, [1:0] security field |
| key_ref | input | 64 | Stored key; byte i is bits [8*i+7:8*i] |
| kw_valid | input | 1 | Key write strobe |
| kw_from_dbg | input | 1 | 1 = the write comes from the debug port, 0 = from secure-memory code |
| kw_idx | input | 3 | Key byte slot being written |
| kw_data | input | 8 | Key byte value |
| erase_done | input | 1 | Pulse: mass erase completed |
| blank_pass | input | 1 | Pulse: blank verification passed |
| secure_o | output | 1 | 1 = memory secured, 0 = unsecured |
| no_redir_o | output | 1 | Redirect-disable bit captured at reset |

## Verification
The key comparator and the erase/blank-check path both drive the same unlock edge, so they can collide. The bench provokes this by arming the erase path first. It then sends seven correct key bytes and a wrong eighth byte, and pulses `blank_pass` in the same cycle as that eighth byte. The expected result is `secure_o`=0 on that edge. The bench then sends a correct key afterwards to show that the failure still locked the key path, which has no visible effect because the block is already unsecured.

// File: rtl/fsec_pkg.sv
// Package: shared constants and types for the flash security controller.
// Assumes an 8-bit option byte with fixed field positions decoded by this block.
package fsec_pkg;
    localparam int OPT_W          = 8;
    localparam int OPT_KEYEN_BIT  = 7;
    localparam int OPT_NORED_BIT  = 6;
    localparam logic [1:0] SEC_OPEN = 2'b10;

    // Fields kept from the option byte after reset.
    typedef struct packed {
        logic       key_en;
        logic       no_redir;
        logic [1:0] sec;
    } opt_fields_t;
endpackage

// File: rtl/fsec_opt_latch.sv
// Option latch: captures the option-byte fields on every clock edge while
// reset is low and holds them until the next reset.
// Assumes opt_in is stable around the reset release.
module fsec_opt_latch
    import fsec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPT_W-1:0] opt_in,
    output opt_fields_t      fields_q
);
    logic opt_unused;
    assign opt_unused = ^opt_in[5:2];

    // Load the fields during reset, hold them afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields_q.key_en   <= opt_in[OPT_KEYEN_BIT];
            fields_q.no_redir <= opt_in[OPT_NORED_BIT];
            fields_q.sec      <= opt_in[1:0];
        end
    end
endmodule

// File: rtl/fsec_key_seq.sv
// Key sequencer: checks in-order key bytes against the stored key.
// It gives a one-cycle unlock or fail indication on the write that ends a
// sequence. After a failure it locks out all further writes until reset.
// Assumes wr_en is already qualified by source, key enable and secure state.
module fsec_key_seq #(
    parameter int KEY_BYTES = 8,
    parameter int BYTE_W    = 8,
    localparam int IDX_W    = $clog2(KEY_BYTES),
    localparam int KEY_W    = KEY_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [KEY_W-1:0]  key_ref,
    output logic              unlock_hit,
    output logic              fail_hit
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_BYTES - 1);

    logic [IDX_W-1:0] ptr_q;
    logic             all_ok_q;
    logic             locked_q;
    logic             take, in_order, byte_ok, at_last;

    // Decide the fate of the write being presented this cycle.
    always_comb begin
        take       = wr_en && !locked_q;
        in_order   = (wr_idx == ptr_q);
        byte_ok    = (wr_data == key_ref[wr_idx*BYTE_W +: BYTE_W]);
        at_last    = (ptr_q == LAST_IDX);
        unlock_hit = take && in_order && at_last && all_ok_q && byte_ok;
        fail_hit   = take && (!in_order || (at_last && !(all_ok_q && byte_ok)));
    end

    // Advance the slot pointer, accumulate the match and latch the lockout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            all_ok_q <= 1'b1;
            locked_q <= 1'b0;
        end else if (take) begin
            if (fail_hit) begin
                locked_q <= 1'b1;
                ptr_q    <= '0;
            end else if (at_last) begin
                ptr_q    <= '0;
                all_ok_q <= 1'b1;
            end else begin
                ptr_q    <= ptr_q + 1'b1;
                all_ok_q <= all_ok_q && byte_ok;
            end
        end
    end
endmodule

// File: rtl/fsec_erase_trk.sv
// Erase tracker: remembers that a mass erase has completed since reset. It
// reports an unlock when a blank-check pass arrives on a later cycle.
// Assumes erase_done and blank_pass are single-cycle status pulses.
module fsec_erase_trk (
    input  logic clk,
    input  logic rst_n,
    input  logic erase_done,
    input  logic blank_pass,
    output logic blank_hit
);
    logic erased_q;

    // A blank pass counts only once an erase has been seen.
    assign blank_hit = blank_pass && erased_q;

    // Remember a completed erase until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          erased_q <= 1'b0;
        else if (erase_done) erased_q <= 1'b1;
    end
endmodule

// File: rtl/flash_sec_ctrl.sv
// Flash security controller top. The secure flag is loaded from the option
// byte during reset and cleared by either a matching key sequence or an
// erase plus blank check. Only reset can set it again.
// Assumes all inputs are synchronous to clk.
module flash_sec_ctrl
    import fsec_pkg::*;
#(
    parameter int KEY_BYTES = 8,
    parameter int BYTE_W    = 8,
    localparam int IDX_W    = $clog2(KEY_BYTES),
    localparam int KEY_W    = KEY_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPT_W-1:0]  opt_byte,
    input  logic [KEY_W-1:0]  key_ref,
    input  logic              kw_valid,
    input  logic              kw_from_dbg,
    input  logic [IDX_W-1:0]  kw_idx,
    input  logic [BYTE_W-1:0] kw_data,
    input  logic              erase_done,
    input  logic              blank_pass,
    output logic              secure_o,
    output logic              no_redir_o
);
    opt_fields_t opt_q;
    logic        key_en_q;
    logic        key_wr_ok;
    logic        key_unlock, key_fail, blank_hit;
    logic        secure_q;

    fsec_opt_latch u_opt (
        .clk      (clk),
        .rst_n    (rst_n),
        .opt_in   (opt_byte),
        .fields_q (opt_q)
    );

    assign key_en_q = opt_q.key_en;

    // A key write counts only from secure code, when enabled, while secured.
    assign key_wr_ok = kw_valid && !kw_from_dbg && key_en_q && secure_q;

    fsec_key_seq #(.KEY_BYTES(KEY_BYTES), .BYTE_W(BYTE_W)) u_key (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (key_wr_ok),
        .wr_idx     (kw_idx),
        .wr_data    (kw_data),
        .key_ref    (key_ref),
        .unlock_hit (key_unlock),
        .fail_hit   (key_fail)
    );

    fsec_erase_trk u_erase (
        .clk        (clk),
        .rst_n      (rst_n),
        .erase_done (erase_done),
        .blank_pass (blank_pass),
        .blank_hit  (blank_hit)
    );

    // Secure flag: reload on reset, clear on either unlock path.
    always_ff @(posedge clk) begin
        if (!rst_n)                       secure_q <= (opt_byte[1:0] != SEC_OPEN);
        else if (key_unlock || blank_hit) secure_q <= 1'b0;
    end

    logic fail_unused;
    assign fail_unused = key_fail;

    assign secure_o   = secure_q;
    assign no_redir_o = opt_q.no_redir;
endmodule

// File: rtl/flash_sec_ctrl_chk.sv
// Checker for flash_sec_ctrl. It is bound to the top and watches the ports
// plus the latched key-enable bit.
module flash_sec_ctrl_chk
    import fsec_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [OPT_W-1:0] opt_byte,
    input logic             kw_valid,
    input logic             kw_from_dbg,
    input logic             blank_pass,
    input logic             key_en,
    input logic             secure_o,
    input logic             no_redir_o
);
    // R1
    sec_load_chk: assert property (@(posedge clk)
        !rst_n |=> (secure_o == ($past(opt_byte[1:0]) != SEC_OPEN)));

    // R2
    nored_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(no_redir_o));

    // R3
    unlock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(secure_o)) |->
            ($past(kw_valid && !kw_from_dbg) || $past(blank_pass)));

    // R4
    keyen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (secure_o && !key_en && !blank_pass) |=> secure_o);

    // R5
    dbg_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (secure_o && kw_valid && kw_from_dbg && !blank_pass) |=> secure_o);

    // R9
    stay_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !secure_o |=> !secure_o);
endmodule

bind flash_sec_ctrl flash_sec_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .opt_byte    (opt_byte),
    .kw_valid    (kw_valid),
    .kw_from_dbg (kw_from_dbg),
    .blank_pass  (blank_pass),
    .key_en      (key_en_q),
    .secure_o    (secure_o),
    .no_redir_o  (no_redir_o)
);

// File: tb/flash_sec_ctrl_test.sv
`timescale 1ns/1ps
module flash_sec_ctrl_test;
    localparam logic [63:0] KEY = 64'hC3A5_1F90_7E24_B86D;
    localparam int MODE_GOOD = 0, MODE_BAD = 1, MODE_DBG = 2, MODE_OOO = 3;

    // {opt_byte[7:0], mode[1:0], expected secure after key}
    localparam logic [10:0] VEC [0:8] = '{
        {8'h80, 2'd0, 1'b0},   // R3 enabled, secured, good key
        {8'h80, 2'd1, 1'b1},   // R6 wrong byte
        {8'h80, 2'd2, 1'b1},   // R5 debug-port key
        {8'h80, 2'd3, 1'b1},   // R6 out of order
        {8'h00, 2'd0, 1'b1},   // R4 key disabled
        {8'h01, 2'd0, 1'b1},   // R4 key disabled, sec 01
        {8'h82, 2'd1, 1'b0},   // R9 unsecured at reset
        {8'h83, 2'd0, 1'b0},   // R3 sec 11
        {8'h81, 2'd0, 1'b0}    // R3 sec 01
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opt_byte = 8'h80;
    logic       kw_valid = 1'b0, kw_from_dbg = 1'b0;
    logic [2:0] kw_idx = '0;
    logic [7:0] kw_data = '0;
    logic       erase_done = 1'b0, blank_pass = 1'b0;
    logic       secure_o, no_redir_o;
    int         checks = 0, fails = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    flash_sec_ctrl uut (
        .clk(clk), .rst_n(rst_n), .opt_byte(opt_byte), .key_ref(KEY),
        .kw_valid(kw_valid), .kw_from_dbg(kw_from_dbg), .kw_idx(kw_idx),
        .kw_data(kw_data), .erase_done(erase_done), .blank_pass(blank_pass),
        .secure_o(secure_o), .no_redir_o(no_redir_o)
    );

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic do_reset(logic [7:0] o);
        @(negedge clk);
        rst_n = 1'b0; opt_byte = o; kw_valid = 1'b0;
        erase_done = 1'b0; blank_pass = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [2:0] idx, logic [7:0] d, logic dbg, logic bp);
        @(negedge clk);
        kw_valid = 1'b1; kw_idx = idx; kw_data = d; kw_from_dbg = dbg; blank_pass = bp;
        @(negedge clk);
        kw_valid = 1'b0; kw_from_dbg = 1'b0; blank_pass = 1'b0;
    endtask

    task automatic pulse_erase();
        @(negedge clk); erase_done = 1'b1;
        @(negedge clk); erase_done = 1'b0;
    endtask

    task automatic pulse_blank();
        @(negedge clk); blank_pass = 1'b1;
        @(negedge clk); blank_pass = 1'b0;
    endtask

    task automatic send_key(int mode);
        for (int i = 0; i < 8; i++) begin
            logic [2:0] idx;
            logic [7:0] d;
            idx = 3'(i);
            if (mode == MODE_OOO && i < 2) idx = (i == 0) ? 3'd1 : 3'd0;
            d = KEY[idx*8 +: 8];
            if (mode == MODE_BAD && i == 3) d = d ^ 8'h01;
            wr(idx, d, (mode == MODE_DBG), 1'b0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all): actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        // Vector table
        foreach (VEC[v]) begin
            do_reset(VEC[v][10:3]);
            chk("R1 reset load", secure_o, VEC[v][4:3] != 2'b10);
            send_key(int'(VEC[v][2:1]));
            chk("R3/R4/R5/R6/R9 key result", secure_o, VEC[v][0]);
        end

        // R2 redirect bit captured and held
        do_reset(8'h40);
        chk("R2 nored set", no_redir_o, 1'b1);
        opt_byte = 8'h00;
        repeat (3) @(negedge clk);
        chk("R2 nored held", no_redir_o, 1'b1);
        do_reset(8'h80);
        chk("R2 nored clear", no_redir_o, 1'b0);

        // R3 timing: still secured after seven bytes
        do_reset(8'h80);
        for (int i = 0; i < 7; i++) wr(3'(i), KEY[i*8 +: 8], 1'b0, 1'b0);
        chk("R3 after seven", secure_o, 1'b1);
        wr(3'd7, KEY[63:56], 1'b0, 1'b0);
        chk("R3 after eighth", secure_o, 1'b0);

        // R8 reset restores secure state
        do_reset(8'h80);
        chk("R8 relock on reset", secure_o, 1'b1);

        // R5 debug write interleaved does not disturb the sequence
        wr(3'd0, 8'h00, 1'b1, 1'b0);
        send_key(MODE_GOOD);
        chk("R5 debug ignored", secure_o, 1'b0);

        // R6 lockout after a failure
        do_reset(8'h80);
        send_key(MODE_BAD);
        send_key(MODE_GOOD);
        chk("R6 lockout", secure_o, 1'b1);

        // R7 blank pass alone is ignored, erase then blank unlocks
        do_reset(8'h00);
        pulse_blank();
        chk("R7 blank without erase", secure_o, 1'b1);
        pulse_erase();
        chk("R7 erase alone", secure_o, 1'b1);
        pulse_blank();
        chk("R7 erase then blank", secure_o, 1'b0);

        // R7 works after a key lockout
        do_reset(8'h80);
        send_key(MODE_BAD);
        pulse_erase();
        pulse_blank();
        chk("R7 after lockout", secure_o, 1'b0);

        // R9 writes after unlock leave it open
        send_key(MODE_BAD);
        wr(3'd5, 8'hFF, 1'b1, 1'b0);
        chk("R9 stays open", secure_o, 1'b0);

        // R10 failing eighth byte with blank pass in the same cycle
        do_reset(8'h80);
        pulse_erase();
        for (int i = 0; i < 7; i++) wr(3'(i), KEY[i*8 +: 8], 1'b0, 1'b0);
        chk("R10 before collision", secure_o, 1'b1);
        wr(3'd7, KEY[63:56] ^ 8'h80, 1'b0, 1'b1);
        chk("R10 collision unlocks", secure_o, 1'b0);
        send_key(MODE_GOOD);
        chk("R10 stays open", secure_o, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule